// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt requests from a set of on-chip peripheral sources and external request pins, plus one non-maskable input, and picks a single winner each arbitration cycle. Each maskable source has a status flag and an enable bit. Groups of sources share one bit of a group-priority control word, and that bit lifts the whole group to the high level. Among requests at the same level, the one with the smaller vector number wins. The controller presents the winning vector number and its vector-table address, in either a 16-bit or a 24-bit addressing mode, and holds them until the consumer acknowledges.

Any maskable source can be marked to start a data-transfer engine rather than interrupt the CPU. Such a request ignores the CPU mask level. When it wins, the controller raises the transfer flag and does not raise the CPU request. The non-maskable input is edge-triggered, latched until acknowledged, and always beats every maskable source.

Top module: `irqc_top`

## Requirements
- R1: A maskable source i takes part in arbitration only when `src_flag[i]` and `src_en[i]` are both 1.
- R2: A pending non-maskable request wins with vector 7 over every maskable source, whatever the mask level and the group bits.
- R3: A source whose group bit is 1 (high level) beats any source whose group bit is 0 (low level), regardless of their vector numbers.
- R4: Among eligible sources at the same level, the lowest vector number wins. Maskable source i has vector 16+i.
- R5: The group map is as follows. Source 0 uses `grp_hi[7]` and source 1 uses `grp_hi[6]`. Sources 2 and 3 use bit 5, sources 4 and 5 use bit 4, and sources 6 and 7 use bit 3. Source 8 (transfer-end) uses bit 2, source 9 uses bit 1, and source 10 uses bit 0.
- R6: For a CPU-bound maskable source, `mask_lvl` = 0 passes both levels, 1 passes only the high level, and 2 or 3 passes none.
- R7: With `addr_mode` = 0, `vec_addr` equals the vector number times 2. With `addr_mode` = 1, it equals the vector number times 4. Both are captured together with the vector.
- R8: A source with `src_xfer[i]` = 1 ignores the mask level. When it wins, `xfer_req` = 1 and `cpu_req` = 0. When any other source wins, `cpu_req` = 1 and `xfer_req` = 0. The two are never 1 together.
- R9: While `cpu_req` or `xfer_req` is 1, the vector, address and both request outputs stay unchanged until a cycle with `ack` = 1. The cycle after that, all outputs are 0. Arbitration resumes on the cycle after that.
- R10: A rising edge on `nmi_in` latches one pending request, which is cleared when its delivery is acknowledged. Holding `nmi_in` high does not raise a second one.
- R11: In reset and with no eligible request, `cpu_req`, `xfer_req`, `vec_num` and `vec_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_flag | input | 11 | Per-source request status flags |
| src_en | input | 11 | Per-source enable bits |
| src_xfer | input | 11 | Per-source route to the data-transfer engine |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| grp_hi | input | 8 | Group priority bits, 1 = high level |
| mask_lvl | input | 2 | CPU mask level (0 all, 1 high only, 2-3 none) |
| addr_mode | input | 1 | 0 = 16-bit vector address, 1 = 24-bit |
| ack | input | 1 | Acknowledge of the presented vector |
| cpu_req | output | 1 | Interrupt request to the CPU |
| xfer_req | output | 1 | Request routed to the data-transfer engine |
| vec_num | output | 8 | Winning vector number |
| vec_addr | output | 24 | Vector-table address of the winner |

## Verification
The hardest case to reach from the ports is one where level, vector order, mask and transfer routing all pull against each other in the same arbitration. An example is a low-vector source that loses to a higher-vector one only because their shared group bits differ, while the mask removes one of them from the CPU path. The bench sweeps every ordered pair of the eleven sources under all four mask levels. Each pairing gets pseudo-random group bits, transfer routing and address mode, and the result is compared with an arithmetic priority function. Separate sequences hold the non-maskable line high across acknowledges and raise a stronger request while a weaker one is being held.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Group-priority bit that governs maskable source i.
   function automatic int unsigned grp_of(input int unsigned i);
      if (i < 2)
         return 7 - i;
      else if (i < 8)
         return 5 - (i - 2) / 2;
      else
         return 2 - (i - 8);
   endfunction

   typedef enum logic [1:0] {
      MASK_NONE = 2'd0,
      MASK_LOW  = 2'd1,
      MASK_ALL  = 2'd2,
      MASK_ALL2 = 2'd3
   } mask_e;

endpackage

// File: rtl/irqc_qualify.sv
module irqc_qualify #(
   parameter int NUM_SRC = 11,
   parameter int NUM_GRP = 8
) (
   input  logic [NUM_SRC-1:0] src_flag,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] src_xfer,
   input  logic [NUM_GRP-1:0] grp_hi,
   input  logic [1:0]         mask_lvl,
   output logic [NUM_SRC-1:0] elig_hi,
   output logic [NUM_SRC-1:0] elig_lo
);
   logic pass_hi, pass_lo;

   assign pass_hi = (mask_lvl == irqc_pkg::MASK_NONE) || (mask_lvl == irqc_pkg::MASK_LOW);
   assign pass_lo = (mask_lvl == irqc_pkg::MASK_NONE);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int unsigned G = irqc_pkg::grp_of(i);
      if (G >= NUM_GRP) begin : g_bad
         $error("irqc_qualify: source %0d maps outside the group word", i);
      end
      logic active, level_hi, passes;
      assign active   = src_flag[i] & src_en[i];
      assign level_hi = grp_hi[G];
      assign passes   = src_xfer[i] | (level_hi ? pass_hi : pass_lo);
      assign elig_hi[i] = active & passes & level_hi;
      assign elig_lo[i] = active & passes & ~level_hi;
   end

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
   parameter int N     = 11,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irqc_vec_addr.sv
module irqc_vec_addr #(
   parameter int VEC_W   = 8,
   parameter int ADDR_W  = 24,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic [VEC_W-1:0]  vec,
   input  logic              wide,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] short_addr;

   if (ADDR_W < VEC_W + 2) begin : g_chk
      $error("irqc_vec_addr: address too narrow for vector width");
   end

   assign short_addr = ADDR_W'({vec, 1'b0});

   if (WIDE_EN) begin : g_wide
      logic [ADDR_W-1:0] long_addr;
      assign long_addr = ADDR_W'({vec, 2'b00});
      assign addr = wide ? long_addr : short_addr;
   end else begin : g_short
      logic unused_wide;
      assign unused_wide = wide;
      assign addr = short_addr;
   end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
   parameter int NUM_SRC  = 11,
   parameter int NUM_GRP  = 8,
   parameter int BASE_VEC = 16,
   parameter int NMI_VEC  = 7,
   parameter int VEC_W    = 8,
   parameter int ADDR_W   = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_flag,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] src_xfer,
   input  logic               nmi_in,
   input  logic [NUM_GRP-1:0] grp_hi,
   input  logic [1:0]         mask_lvl,
   input  logic               addr_mode,
   input  logic               ack,
   output logic               cpu_req,
   output logic               xfer_req,
   output logic [VEC_W-1:0]   vec_num,
   output logic [ADDR_W-1:0]  vec_addr
);
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (BASE_VEC + NUM_SRC > (1 << VEC_W)) begin : g_chk_vec
      $error("irqc_top: vectors do not fit VEC_W");
   end
   if (NMI_VEC >= BASE_VEC) begin : g_chk_nmi
      $error("irqc_top: non-maskable vector must precede maskable ones");
   end

   logic [NUM_SRC-1:0] elig_hi, elig_lo;
   logic               hi_found, lo_found;
   logic [IDX_W-1:0]   hi_idx, lo_idx;

   irqc_qualify #(.NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP)) qual_i (
      .src_flag(src_flag), .src_en(src_en), .src_xfer(src_xfer),
      .grp_hi(grp_hi), .mask_lvl(mask_lvl),
      .elig_hi(elig_hi), .elig_lo(elig_lo)
   );

   irqc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) pick_hi_i (
      .req(elig_hi), .found(hi_found), .idx(hi_idx)
   );

   irqc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) pick_lo_i (
      .req(elig_lo), .found(lo_found), .idx(lo_idx)
   );

   // Non-maskable edge capture
   logic nmi_q, nmi_pend, nmi_rise, nmi_now, held_nmi, holding;
   assign nmi_rise = nmi_in & ~nmi_q;
   assign nmi_now  = nmi_pend | nmi_rise;
   assign holding  = cpu_req | xfer_req;

   // Winner selection
   logic             win_v, win_x;
   logic [VEC_W-1:0] win_vec;
   logic [ADDR_W-1:0] win_addr;

   always_comb begin
      win_v   = 1'b1;
      win_x   = 1'b0;
      win_vec = VEC_W'(NMI_VEC);
      if (nmi_now) begin
         win_vec = VEC_W'(NMI_VEC);
      end else if (hi_found) begin
         win_vec = VEC_W'(BASE_VEC) + VEC_W'(hi_idx);
         win_x   = src_xfer[hi_idx];
      end else if (lo_found) begin
         win_vec = VEC_W'(BASE_VEC) + VEC_W'(lo_idx);
         win_x   = src_xfer[lo_idx];
      end else begin
         win_v   = 1'b0;
         win_vec = '0;
      end
   end

   irqc_vec_addr #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .WIDE_EN(1'b1)) addr_i (
      .vec(win_vec), .wide(addr_mode), .addr(win_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmi_q    <= 1'b0;
         nmi_pend <= 1'b0;
         held_nmi <= 1'b0;
         cpu_req  <= 1'b0;
         xfer_req <= 1'b0;
         vec_num  <= '0;
         vec_addr <= '0;
      end else begin
         nmi_q <= nmi_in;
         if (nmi_rise)
            nmi_pend <= 1'b1;
         else if (holding && ack && held_nmi)
            nmi_pend <= 1'b0;

         if (!holding) begin
            cpu_req  <= win_v & ~win_x;
            xfer_req <= win_v & win_x;
            vec_num  <= win_vec;
            vec_addr <= win_v ? win_addr : '0;
            held_nmi <= win_v & nmi_now;
         end else if (ack) begin
            cpu_req  <= 1'b0;
            xfer_req <= 1'b0;
            vec_num  <= '0;
            vec_addr <= '0;
            held_nmi <= 1'b0;
         end
      end
   end

   // R8
   excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_req && xfer_req));

   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req || xfer_req) && !ack |=> $stable(vec_num) && $stable(vec_addr)
                                        && $stable(cpu_req) && $stable(xfer_req));

   // R9
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req || xfer_req) && ack |=> !cpu_req && !xfer_req);

   // R2
   nmi_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pend && !(cpu_req || xfer_req) |=> cpu_req && (vec_num == VEC_W'(NMI_VEC)));

endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [10:0] src_flag, src_en, src_xfer;
   logic        nmi_in;
   logic [7:0]  grp_hi;
   logic [1:0]  mask_lvl;
   logic        addr_mode, ack;
   logic        cpu_req, xfer_req;
   logic [7:0]  vec_num;
   logic [23:0] vec_addr;

   int checks = 0;
   int errors = 0;
   logic [31:0] seed = 32'h1badcafe;

   always #4 clk = ~clk;

   irqc_top dut_i (
      .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
      .src_xfer(src_xfer), .nmi_in(nmi_in), .grp_hi(grp_hi),
      .mask_lvl(mask_lvl), .addr_mode(addr_mode), .ack(ack),
      .cpu_req(cpu_req), .xfer_req(xfer_req), .vec_num(vec_num),
      .vec_addr(vec_addr)
   );

   function automatic logic [31:0] rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   // Group bit per source, from the R5 map
   function automatic int grp_b(input int i);
      case (i)
         0: return 7;
         1: return 6;
         2, 3: return 5;
         4, 5: return 4;
         6, 7: return 3;
         8: return 2;
         9: return 1;
         default: return 0;
      endcase
   endfunction

   function automatic void ref_pick(input logic [10:0] fl, en, xs, input logic [7:0] ct,
                                    input logic [1:0] mk, input bit nmi,
                                    output int vec, output bit isx, output bit vld);
      vld = 0; vec = 0; isx = 0;
      if (nmi) begin vec = 7; vld = 1; return; end
      for (int pass = 0; pass < 2; pass++) begin
         for (int i = 0; i < 11; i++) begin
            bit hi;
            hi = ct[grp_b(i)];
            if (!vld && ((pass == 0) == hi) && fl[i] && en[i] &&
                (xs[i] || mk == 2'd0 || (mk == 2'd1 && hi))) begin
               vld = 1; vec = 16 + i; isx = xs[i];
            end
         end
      end
   endfunction

   task automatic check_out(input string tag, input bit vld, input int vec,
                            input bit isx, input bit mode);
      logic        e_cpu, e_x;
      logic [7:0]  e_vec;
      logic [23:0] e_addr;
      e_cpu  = vld & ~isx;
      e_x    = vld & isx;
      e_vec  = vld ? 8'(vec) : 8'd0;
      e_addr = vld ? (mode ? 24'(vec * 4) : 24'(vec * 2)) : 24'd0;
      checks++;
      if (cpu_req !== e_cpu || xfer_req !== e_x || vec_num !== e_vec || vec_addr !== e_addr) begin
         errors++;
         $display("FAIL %s: got cpu=%0b xfer=%0b vec=%0d addr=%h, expected cpu=%0b xfer=%0b vec=%0d addr=%h",
                  tag, cpu_req, xfer_req, vec_num, vec_addr, e_cpu, e_x, e_vec, e_addr);
      end
   endtask

   task automatic clear_inputs();
      src_flag = '0; src_en = '0; src_xfer = '0; nmi_in = 0;
      grp_hi = '0; mask_lvl = '0; addr_mode = 0; ack = 0;
   endtask

   // Drive, check the captured winner, acknowledge, check cleared.
   task automatic one_case(input string tag, input logic [10:0] fl, en, xs,
                           input logic [7:0] ct, input logic [1:0] mk, input bit mode);
      int vec; bit isx, vld;
      @(negedge clk);
      src_flag = fl; src_en = en; src_xfer = xs; grp_hi = ct; mask_lvl = mk; addr_mode = mode;
      ref_pick(fl, en, xs, ct, mk, 1'b0, vec, isx, vld);
      @(negedge clk);
      check_out(tag, vld, vec, isx, mode);
      ack = 1;
      @(negedge clk);
      ack = 0;
      clear_inputs();
      check_out("R9 ack clears", 0, 0, 0, 0);
   endtask

   initial begin
      clear_inputs();
      rst_n = 0;
      repeat (3) @(negedge clk);
      // R11 reset state
      check_out("R11 reset", 0, 0, 0, 0);
      rst_n = 1;
      @(negedge clk);
      check_out("R11 idle", 0, 0, 0, 0);

      // R1 flag without enable, enable without flag
      one_case("R1 flag only", 11'h7ff, 11'h000, 11'h000, 8'hff, 2'd0, 0);
      one_case("R1 enable only", 11'h000, 11'h7ff, 11'h000, 8'hff, 2'd0, 0);
      one_case("R1 partial", 11'h0f0, 11'h03c, 11'h000, 8'h00, 2'd0, 1);

      // R3/R4/R5/R6/R7/R8 pair sweep under all mask levels
      for (int mk = 0; mk < 4; mk++) begin
         for (int a = 0; a < 11; a++) begin
            for (int b = 0; b < 11; b++) begin
               logic [10:0] fl, xs;
               logic [31:0] r;
               r  = rnd();
               fl = (11'd1 << a) | (11'd1 << b);
               xs = 11'(r[10:0] & r[26:16]);
               one_case("R3/R4/R5/R6/R7/R8 pair", fl, 11'h7ff, xs, r[31:24] ^ r[7:0],
                        2'(mk), r[13]);
            end
         end
      end

      // R5 group map: lift one bit, only its members win over source 0
      for (int g = 0; g < 8; g++) begin
         one_case("R5 group lift", 11'h7ff, 11'h7ff, 11'h000, 8'(1 << g), 2'd1, 1);
      end

      // R2/R10 non-maskable edge with level held
      @(negedge clk);
      src_flag = 11'h001; src_en = 11'h001; grp_hi = 8'hff; mask_lvl = 2'd3; nmi_in = 1;
      @(negedge clk);
      check_out("R2 nmi beats all", 1, 7, 0, 0);
      ack = 1;
      @(negedge clk);
      ack = 0; mask_lvl = 2'd0;
      check_out("R9 nmi ack clears", 0, 0, 0, 0);
      @(negedge clk);
      check_out("R10 held level no retrigger", 1, 16, 0, 0);
      ack = 1;
      @(negedge clk);
      ack = 0; src_flag = '0;
      @(negedge clk);
      check_out("R10 single nmi", 0, 0, 0, 0);
      nmi_in = 0;
      @(negedge clk);
      nmi_in = 1; addr_mode = 1;
      @(negedge clk);
      check_out("R10 new edge", 1, 7, 0, 1);
      ack = 1;
      @(negedge clk);
      ack = 0;
      clear_inputs();
      @(negedge clk);

      // R9 hold while a stronger request arrives
      src_flag = 11'h008; src_en = 11'h7ff; addr_mode = 1;
      @(negedge clk);
      check_out("R9 first winner", 1, 19, 0, 1);
      src_flag = 11'h009; addr_mode = 0; grp_hi = 8'h80;
      repeat (3) begin
         @(negedge clk);
         check_out("R9 held stable", 1, 19, 0, 1);
      end
      ack = 1;
      @(negedge clk);
      ack = 0;
      check_out("R9 cleared after ack", 0, 0, 0, 0);
      @(negedge clk);
      check_out("R9 rearbitrate", 1, 16, 0, 0);
      ack = 1;
      @(negedge clk);
      clear_inputs();

      // R8 transfer route ignores full mask
      one_case("R8 xfer bypasses mask", 11'h400, 11'h400, 11'h400, 8'h00, 2'd3, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule